// File: doc/BRIEF.md
# Chip Select Address Decoder

This block watches the start of every bus cycle and compares the cycle address against nine programmable regions. Seven are chip-select regions and two are DRAM regions. It picks the target of the cycle and gives the bus side what that target needs: the chip-select strobes, the DRAM select flags, the static port width, whether bursting is allowed, whether the cycle waits for an external termination, and an automatic acknowledge after a programmed number of wait cycles.

A chip-select region has three registers: a base, a mask and a control word. A DRAM region has a base and a mask. All of them are written through a simple synchronous write port. Chip select 0 answers every address after reset, so a boot memory can be reached before software has programmed anything.

Overlapping matches are settled by fixed rules:
- Several chip selects may fire together. That cycle then falls back to safe default timing.
- Any overlap that involves a DRAM region is reported as a conflict, and no chip-select strobe is driven.

The decoded result is registered when a cycle starts. It is held until the cycle ends.

Top module: `cs_decoder`

## Requirements
- R1: After reset, chip select 0 matches every address whatever its base, mask or valid bit. It stops doing so from the cycle after the first write to its mask register (select 8).
- R2: A region matches when its valid bit is set and `(cyc_addr[31:16] ^ base) & ~mask` is zero. A mask bit of 1 ignores that address bit. A region whose valid bit is clear never matches.
- R3: Register selects on `wr_sel` are as follows:
  - 0..6: chip-select base, taken from `wr_data[15:0]`.
  - 8..14: chip-select mask from `wr_data[15:0]`, with the valid bit in `wr_data[16]`.
  - 16..22: chip-select control word, taken from `wr_data[7:0]`.
  - 24/25: DRAM 0/1 base.
  - 26/27: DRAM 0/1 mask, with the valid bit in `wr_data[16]`.
- R4: The control word has these fields:
  - Bits [1:0]: port size, where 01 means 8-bit, 10 means 16-bit, and 00 or 11 mean 32-bit.
  - Bit [2]: burst enable.
  - Bit [3]: auto-acknowledge enable.
  - Bits [7:4]: wait-state count.
- R5: `port_size` is encoded 00 for 32-bit, 01 for 8-bit and 10 for 16-bit. When exactly one chip select matches and no DRAM region matches, the outputs come from that region's control word:
  - `cs_sel` has only that bit set.
  - `port_size` follows the port-size field.
  - `burst_ok` follows the burst-enable bit.
  - `ext_term` is the inverse of the auto-acknowledge enable.
- R6: When two or more chip selects match and no DRAM region matches, every matching strobe is driven. The cycle is then forced to 32-bit, `burst_ok` low and `ext_term` high, and no auto-acknowledge is given.
- R7: When nothing matches, `cs_sel` and `dram_sel` are zero, `port_size` is 32-bit, `burst_ok` is low, `ext_term` is high, and there is no acknowledge.
- R8: When exactly one DRAM region matches and no chip select matches, only that `dram_sel` bit is set, and `ext_term`, `burst_ok` and `auto_ack` stay low.
- R9: A match in both DRAM regions, or in a DRAM region together with any chip select, raises `conflict`. In that case all `cs_sel` and `dram_sel` bits and `ext_term` are low.
- R10: With auto-acknowledge enabled and N wait states, `auto_ack` is high for exactly one clock. That clock is N clocks after the first clock in which the decoded outputs are visible.
- R11: The decoded outputs appear one clock after `cyc_start` is sampled high. They are held unchanged while neither `cyc_start` nor `cyc_end` is high, and they return to all zero one clock after `cyc_end` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 5 | Register select |
| wr_data | input | 32 | Register write data |
| cyc_start | input | 1 | Bus cycle start, address valid |
| cyc_addr | input | 32 | Bus cycle address |
| cyc_end | input | 1 | Bus cycle end |
| cs_sel | output | 7 | Chip-select strobes, active high |
| dram_sel | output | 2 | DRAM region select flags |
| port_size | output | 2 | Effective port width code |
| burst_ok | output | 1 | Burst allowed |
| ext_term | output | 1 | Cycle waits for external termination |
| conflict | output | 1 | Undefined overlap involving a DRAM region |
| auto_ack | output | 1 | One-clock automatic acknowledge |

## Verification
The bench first runs with nothing programmed. A global chip select 0 that failed to overlap a freshly programmed region would show a single strobe instead of the forced multi-match timing. A global chip select 0 that never left global mode would keep matching an unrelated address after its mask write.

The bench then programs nested chip-select regions, overlapping DRAM regions and a chip select that sits inside a DRAM window. A decoder that let one region win would leave out a strobe. One that kept strobes during a conflict would drive a device that must stay idle.

The edges of masked ranges, an invalid region and the reserved port-size code catch compare and field decode errors. Counting the acknowledge cycle by cycle catches off-by-one wait-state errors, repeated pulses and acknowledges given for forced external cycles.

// File: rtl/cs_decoder.sv
module cs_decoder #(
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int NCS = 7,
  parameter int NDR = 2,
  parameter int MW  = 16,
  parameter int WSW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [4:0]     wr_sel,
  input  logic [DW-1:0]  wr_data,
  input  logic           cyc_start,
  input  logic [AW-1:0]  cyc_addr,
  input  logic           cyc_end,
  output logic [NCS-1:0] cs_sel,
  output logic [NDR-1:0] dram_sel,
  output logic [1:0]     port_size,
  output logic           burst_ok,
  output logic           ext_term,
  output logic           conflict,
  output logic           auto_ack
);
  localparam int LO = AW - MW;
  localparam int CW = 4 + WSW;

  logic [MW-1:0]  cs_base [NCS];
  logic [MW-1:0]  cs_mask [NCS];
  logic [CW-1:0]  cs_ctrl [NCS];
  logic [NCS-1:0] cs_vld;
  logic [MW-1:0]  dr_base [NDR];
  logic [MW-1:0]  dr_mask [NDR];
  logic [NDR-1:0] dr_vld;
  logic           glob0;

  wire [1:0] grp = wr_sel[4:3];
  wire [2:0] idx = wr_sel[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCS; i++) begin
        cs_base[i] <= '0;
        cs_mask[i] <= '0;
        cs_ctrl[i] <= '0;
      end
      for (int j = 0; j < NDR; j++) begin
        dr_base[j] <= '0;
        dr_mask[j] <= '0;
      end
      cs_vld <= '0;
      dr_vld <= '0;
      glob0  <= 1'b1;
    end else if (wr_en) begin
      for (int i = 0; i < NCS; i++) begin
        if (idx == 3'(i)) begin
          if (grp == 2'd0) cs_base[i] <= wr_data[MW-1:0];
          if (grp == 2'd1) begin
            cs_mask[i] <= wr_data[MW-1:0];
            cs_vld[i]  <= wr_data[MW];
          end
          if (grp == 2'd2) cs_ctrl[i] <= wr_data[CW-1:0];
        end
      end
      for (int j = 0; j < NDR; j++) begin
        if (grp == 2'd3 && wr_sel[2] == 1'b0 && wr_sel[0] == 1'(j)) begin
          if (wr_sel[1]) begin
            dr_mask[j] <= wr_data[MW-1:0];
            dr_vld[j]  <= wr_data[MW];
          end else begin
            dr_base[j] <= wr_data[MW-1:0];
          end
        end
      end
      if (grp == 2'd1 && idx == 3'd0) glob0 <= 1'b0;
    end
  end

  logic [NCS-1:0] cs_hit;
  logic [NDR-1:0] dr_hit;
  wire  [MW-1:0]  upper = cyc_addr[AW-1:LO];

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    wire in_range = ((upper ^ cs_base[i]) & ~cs_mask[i]) == '0;
    if (i == 0) begin : g_boot
      assign cs_hit[i] = glob0 || (cs_vld[i] && in_range);
    end else begin : g_norm
      assign cs_hit[i] = cs_vld[i] && in_range;
    end
  end

  for (genvar j = 0; j < NDR; j++) begin : g_dr
    assign dr_hit[j] = dr_vld[j] && (((upper ^ dr_base[j]) & ~dr_mask[j]) == '0);
  end

  wire one_cs = (cs_hit != '0) && ((cs_hit & (cs_hit - 1'b1)) == '0);
  wire any_cs = cs_hit != '0;
  wire one_dr = (dr_hit != '0) && ((dr_hit & (dr_hit - 1'b1)) == '0);
  wire any_dr = dr_hit != '0;

  logic [CW-1:0] hit_ctrl;
  always_comb begin
    hit_ctrl = '0;
    for (int i = 0; i < NCS; i++) hit_ctrl |= {CW{cs_hit[i]}} & cs_ctrl[i];
  end

  logic [NCS-1:0] n_cs;
  logic [NDR-1:0] n_dr;
  logic [1:0]     n_ps;
  logic           n_burst, n_ext, n_conf, n_acken;
  logic [WSW-1:0] n_ws;

  always_comb begin
    n_cs = '0; n_dr = '0; n_ps = 2'b00; n_burst = 1'b0;
    n_ext = 1'b0; n_conf = 1'b0; n_acken = 1'b0; n_ws = '0;
    if (any_dr && (any_cs || !one_dr)) begin
      n_conf = 1'b1;
    end else if (any_dr) begin
      n_dr = dr_hit;
    end else if (one_cs) begin
      n_cs    = cs_hit;
      n_ps    = (hit_ctrl[1:0] == 2'b11) ? 2'b00 : hit_ctrl[1:0];
      n_burst = hit_ctrl[2];
      n_acken = hit_ctrl[3];
      n_ext   = !hit_ctrl[3];
      n_ws    = hit_ctrl[CW-1:4];
    end else begin
      n_cs  = cs_hit;
      n_ext = 1'b1;
    end
  end

  logic           active, acken_q, ack_done;
  logic [WSW-1:0] ws_q, cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || (cyc_end && !cyc_start)) begin
      cs_sel <= '0; dram_sel <= '0; port_size <= 2'b00; burst_ok <= 1'b0;
      ext_term <= 1'b0; conflict <= 1'b0; acken_q <= 1'b0; ws_q <= '0;
      active <= 1'b0; cnt <= '0; ack_done <= 1'b0;
    end else if (cyc_start) begin
      cs_sel <= n_cs; dram_sel <= n_dr; port_size <= n_ps; burst_ok <= n_burst;
      ext_term <= n_ext; conflict <= n_conf; acken_q <= n_acken; ws_q <= n_ws;
      active <= 1'b1; cnt <= '0; ack_done <= 1'b0;
    end else if (active) begin
      if (auto_ack) ack_done <= 1'b1;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  assign auto_ack = active && acken_q && !ack_done && (cnt == ws_q);

  a_r9_conflict_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    conflict |-> (cs_sel == '0 && dram_sel == '0 && !ext_term));
  a_r6_multi_forced: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cs_sel) > 1) |-> (!burst_ok && ext_term && port_size == 2'b00 && !auto_ack));
  a_r8_dram_alone: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_sel != '0) |-> (cs_sel == '0 && !ext_term && !auto_ack && $onehot0(dram_sel)));
  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_ack && !cyc_start) |=> !auto_ack);
  a_r10_ack_owner: assert property (@(posedge clk) disable iff (!rst_n)
    auto_ack |-> (!ext_term && $countones(cs_sel) == 1));
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cyc_start && !cyc_end) |=> ($stable(cs_sel) && $stable(dram_sel) && $stable(port_size)
                                  && $stable(ext_term) && $stable(conflict)));
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !cyc_start) |=> (cs_sel == '0 && dram_sel == '0 && !auto_ack && !conflict));
endmodule

// File: tb/test_cs_decoder.sv
module test_cs_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        cyc_start = 1'b0;
  logic [31:0] cyc_addr = '0;
  logic        cyc_end = 1'b0;
  logic [6:0]  cs_sel;
  logic [1:0]  dram_sel, port_size;
  logic        burst_ok, ext_term, conflict, auto_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cs_decoder i_cs_decoder (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cyc_start(cyc_start), .cyc_addr(cyc_addr), .cyc_end(cyc_end),
    .cs_sel(cs_sel), .dram_sel(dram_sel), .port_size(port_size), .burst_ok(burst_ok),
    .ext_term(ext_term), .conflict(conflict), .auto_ack(auto_ack)
  );

  // {addr, cs, dram, ps, burst, ext, conflict}
  localparam logic [45:0] VEC [NV] = '{
    {32'h0012_3456, 7'h01, 2'b00, 2'b01, 1'b1, 1'b0, 1'b0},
    {32'h1003_0000, 7'h02, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0},
    {32'h100A_0000, 7'h06, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0},
    {32'h1009_FFFF, 7'h06, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0},
    {32'h2000_0000, 7'h00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0},
    {32'h4000_1234, 7'h00, 2'b01, 2'b00, 1'b0, 1'b0, 1'b0},
    {32'h4850_0000, 7'h00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1},
    {32'h4100_0000, 7'h00, 2'b00, 2'b00, 1'b0, 1'b0, 1'b1},
    {32'h1000_0000, 7'h02, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0},
    {32'h9999_0000, 7'h00, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0},
    {32'h100F_0000, 7'h06, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0},
    {32'h6000_0000, 7'h20, 2'b00, 2'b00, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] s, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic start(logic [31:0] a);
    @(negedge clk); cyc_start = 1'b1; cyc_addr = a;
    @(negedge clk); cyc_start = 1'b0;
  endtask

  task automatic finish_cycle();
    @(negedge clk); cyc_end = 1'b1;
    @(negedge clk); cyc_end = 1'b0;
  endtask

  function automatic logic [13:0] outs();
    return {cs_sel, dram_sel, port_size, burst_ok, ext_term, conflict};
  endfunction

  task automatic ack_profile(string req, logic [31:0] a, int ws);
    start(a);
    for (int k = 0; k < 8; k++) begin
      check(req, {31'd0, auto_ack}, {31'd0, (k == ws)});
      @(negedge clk);
    end
    finish_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 reset idle", {18'd0, outs()}, 32'd0);
    check("R11 reset ack", {31'd0, auto_ack}, 32'd0);

    // R1: global chip select 0, default control word
    start(32'hDEAD_BEEF);
    check("R1 global any address", {18'd0, outs()}, {18'd0, 7'h01, 2'b00, 2'b00, 1'b0, 1'b1, 1'b0});
    finish_cycle();
    check("R11 release", {18'd0, outs()}, 32'd0);
    wr(5'd1, 32'h0000_1000);
    wr(5'd9, 32'h0001_000F);
    wr(5'd17, 32'h0000_0002);
    start(32'h1003_0000);
    check("R1 R6 global overlaps region", {25'd0, cs_sel}, 32'h03);
    check("R6 forced ext", {29'd0, port_size, ext_term}, {29'd0, 2'b00, 1'b1});
    finish_cycle();
    wr(5'd8, 32'h0000_00FF);
    start(32'hDEAD_BEEF);
    check("R1 global left after mask write", {25'd0, cs_sel}, 32'h00);
    check("R7 no match ext", {29'd0, port_size, ext_term}, {29'd0, 2'b00, 1'b1});
    finish_cycle();

    // R3 R4 programming
    wr(5'd0, 32'h0000_0000); wr(5'd8, 32'h0001_00FF); wr(5'd16, 32'h0000_003D);
    wr(5'd2, 32'h0000_1008); wr(5'd10, 32'h0001_0007); wr(5'd18, 32'h0000_0008);
    wr(5'd3, 32'h0000_2000); wr(5'd11, 32'h0000_0000);
    wr(5'd4, 32'h0000_4100); wr(5'd12, 32'h0001_0000);
    wr(5'd5, 32'h0000_6000); wr(5'd13, 32'h0001_0000); wr(5'd21, 32'h0000_0007);
    wr(5'd24, 32'h0000_4000); wr(5'd26, 32'h0001_0FFF);
    wr(5'd25, 32'h0000_4800); wr(5'd27, 32'h0001_00FF);

    // R2 R5 R6 R7 R8 R9: table walk
    for (int v = 0; v < NV; v++) begin
      start(VEC[v][45:14]);
      check($sformatf("R2 R5-R9 vector %0d", v), {18'd0, outs()}, {18'd0, VEC[v][13:0]});
      finish_cycle();
    end

    // R10: wait states and single pulse
    ack_profile("R10 ws3 ack", 32'h0012_0000, 3);
    ack_profile("R10 no ack multi R6", 32'h100A_0000, 99);
    ack_profile("R10 no ack ext R5", 32'h1003_0000, 99);
    wr(5'd16, 32'h0000_000D);
    ack_profile("R10 ws0 ack", 32'h0012_0000, 0);
    wr(5'd16, 32'h0000_00F9);
    ack_profile("R10 ws15 beyond window", 32'h0012_0000, 99);

    // R11: hold while cycle open, ignore address change
    start(32'h1003_0000);
    cyc_addr = 32'h4850_0000;
    repeat (5) @(negedge clk);
    check("R11 held", {18'd0, outs()}, {18'd0, 7'h02, 2'b00, 2'b10, 1'b0, 1'b1, 1'b0});
    finish_cycle();
    check("R11 released", {18'd0, outs()}, 32'd0);

    // R2: valid bit clear disables region
    wr(5'd9, 32'h0000_000F);
    start(32'h1003_0000);
    check("R2 invalid region", {25'd0, cs_sel}, 32'h00);
    finish_cycle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule